// File: doc/BRIEF.md
# Multi-mode microcontroller I/O port

This block is one byte-wide bidirectional port of a programmable peripheral that sits on a microcontroller bus. Each of its pins takes its output value from one of three sources:

- a data-out register under software control;
- an output of the programmable logic array;
- a byte of the most recently latched bus address.

The output enable is shared by all three sources. It is the OR of a per-pin direction bit and an external output-enable product term.

Software reaches four byte registers through a small chip-selected register window. The control register picks address output per pin. The direction register sets per-pin drive. The data-out register holds the values to drive. The data-in register returns pad levels after a two-flop synchronizer.

The address latch follows a multiplexed address/data bus. While the latch strobe is high, the block tracks the address lines. On the cycle the strobe falls, it commits the last tracked value.

Two parameters shape the port:

- `ADDR_BYTE` picks which address byte the port presents: 0 gives bits 7..0, 1 gives bits 15..8.
- `HAS_CTRL = 0` builds the port with no control register, so it is fixed in register-driven mode.

Register accesses complete in a fixed number of cycles and never stall. The bus side therefore has no back-pressure. Every other pin of the block is a plain level.

Top module: `mio_port`

## Requirements
- R1: After reset, the control, direction and data-out registers read 0, `bus_rdata` is 0, and with `oe_term` at 0 every `pad_oe` bit is 0.
- R2: A pin with `plc_sel` = 0 and control bit = 0 is in register-driven mode: `pad_out` equals its data-out register bit.
- R3: For every pin in every mode, `pad_oe` equals the direction bit OR the pin's `oe_term` bit. A pin with both at 0 is an undriven input.
- R4: A pin with `plc_sel` = 1 is in logic-driven mode: `pad_out` equals its `plc_out` bit, whatever the control bit holds.
- R5: A pin with `plc_sel` = 0 and control bit = 1 is in address-out mode: `pad_out` equals the matching bit of the selected latched address byte.
- R6: The address latch takes the `ad_in` value last seen while `ale` was high, and commits it on the first clock edge at which `ale` is sampled low. At any other time the latch holds, whatever `ad_in` does.
- R7: `ADDR_BYTE` = 0 presents latched address bits 7..0, and `ADDR_BYTE` = 1 presents bits 15..8.
- R8: A read of the data-in offset returns the level that `pad_in` had two clock edges before the edge that samples the read. A pad change made just before the read strobe is not yet visible.
- R9: The offsets are 0 = control, 1 = direction, 2 = data-out, 3 = data-in.
  - A write is `bus_cs` = 1 with `bus_wr` = 1. It takes effect on that edge.
  - A read is `bus_cs` = 1 with `bus_wr` = 0. Its data appears on `bus_rdata` after that edge.
  - Registers read back what was written.
  - A write to offset 3 changes no register.
- R10: With `HAS_CTRL` = 0, offset 0 always reads 0 and writes to it are ignored, so no pin ever enters address-out mode.
- R11: `bus_rdata` keeps its value in any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Register window select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ofs | input | 2 | Register offset |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| ale | input | 1 | Address latch strobe |
| ad_in | input | AW | Address lines of the multiplexed bus |
| plc_sel | input | W | Per-pin logic-driven mode select |
| plc_out | input | W | Logic array output values |
| oe_term | input | W | External output-enable product term |
| pad_in | input | W | Pad input levels |
| pad_out | output | W | Pad output values |
| pad_oe | output | W | Pad output enables |

## Verification
The hardest situation to reach is an address-out pin whose latched byte is not the current value of `ad_in`. This needs a complete strobe cycle, followed by address-line traffic while the strobe is low, with the control bit set in between. The stimulus produces it by interleaving random strobe cycles, register writes and deliberate address-line changes while `ale` is low.

Two further instances share the same stimulus. One is built with `ADDR_BYTE` = 1 and the other with no control register, so each pin mode is compared across the three builds on every step. A directed sequence also places a pad change immediately before a data-in read, to expose the synchronizer delay.

// File: rtl/mio_pkg.sv
package mio_pkg;
  localparam int OFS_W = 2;

  typedef enum logic [OFS_W-1:0] {
    OFS_CTRL = 2'd0,
    OFS_DIR  = 2'd1,
    OFS_DOUT = 2'd2,
    OFS_DIN  = 2'd3
  } mio_ofs_e;

  typedef enum logic [1:0] {
    SRC_REG   = 2'd0,
    SRC_LOGIC = 2'd1,
    SRC_ADDR  = 2'd2
  } mio_src_e;
endpackage

// File: rtl/mio_sync.sv
module mio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/mio_alat.sv
module mio_alat #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic [AW-1:0] ad_in,
  output logic [AW-1:0] addr_q
);
  logic          ale_q;
  logic [AW-1:0] track_q;
  logic          ale_fall;

  assign ale_fall = ale_q & ~ale;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_q   <= 1'b0;
      track_q <= '0;
      addr_q  <= '0;
    end else begin
      ale_q <= ale;
      if (ale)      track_q <= ad_in;
      if (ale_fall) addr_q  <= track_q;
    end
  end
endmodule

// File: rtl/mio_regs.sv
module mio_regs
  import mio_pkg::*;
#(
  parameter int W        = 8,
  parameter bit HAS_CTRL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             wr,
  input  logic [OFS_W-1:0] ofs,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     din_sync,
  output logic [W-1:0]     ctrl_q,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     dout_q,
  output logic [W-1:0]     rdata
);
  logic     wr_en;
  logic     rd_en;
  mio_ofs_e ofs_e;
  logic [W-1:0] rd_mux;

  assign ofs_e = mio_ofs_e'(ofs);
  assign wr_en = cs & wr;
  assign rd_en = cs & ~wr;

  if (HAS_CTRL) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rst_n)                           ctrl_q <= '0;
      else if (wr_en && ofs_e == OFS_CTRL)  ctrl_q <= wdata;
    end
  end else begin : g_no_ctrl
    assign ctrl_q = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
    end else if (wr_en) begin
      if (ofs_e == OFS_DIR)  dir_q  <= wdata;
      if (ofs_e == OFS_DOUT) dout_q <= wdata;
    end
  end

  always_comb begin
    unique case (ofs_e)
      OFS_CTRL: rd_mux = ctrl_q;
      OFS_DIR:  rd_mux = dir_q;
      OFS_DOUT: rd_mux = dout_q;
      default:  rd_mux = din_sync;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/mio_pinmux.sv
module mio_pinmux
  import mio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] ctrl,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] dout,
  input  logic [W-1:0] plc_sel,
  input  logic [W-1:0] plc_out,
  input  logic [W-1:0] oe_term,
  input  logic [W-1:0] addr_byte,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    mio_src_e src;

    always_comb begin
      if (plc_sel[i])   src = SRC_LOGIC;
      else if (ctrl[i]) src = SRC_ADDR;
      else              src = SRC_REG;
    end

    always_comb begin
      unique case (src)
        SRC_LOGIC: pad_out[i] = plc_out[i];
        SRC_ADDR:  pad_out[i] = addr_byte[i];
        default:   pad_out[i] = dout[i];
      endcase
    end

    assign pad_oe[i] = dir[i] | oe_term[i];
  end
endmodule

// File: rtl/mio_port.sv
module mio_port
  import mio_pkg::*;
#(
  parameter int W         = 8,
  parameter int AW        = 16,
  parameter bit HAS_CTRL  = 1'b1,
  parameter int ADDR_BYTE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_cs,
  input  logic             bus_wr,
  input  logic [OFS_W-1:0] bus_ofs,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  input  logic             ale,
  input  logic [AW-1:0]    ad_in,
  input  logic [W-1:0]     plc_sel,
  input  logic [W-1:0]     plc_out,
  input  logic [W-1:0]     oe_term,
  input  logic [W-1:0]     pad_in,
  output logic [W-1:0]     pad_out,
  output logic [W-1:0]     pad_oe
);
  localparam int LANES    = AW / W;
  localparam int SYNC_LEN = 2;

  logic [W-1:0]  ctrl_q;
  logic [W-1:0]  dir_q;
  logic [W-1:0]  dout_q;
  logic [W-1:0]  din_sync;
  logic [AW-1:0] addr_q;
  logic [W-1:0]  addr_byte;

  initial begin
    if (ADDR_BYTE < 0 || ADDR_BYTE >= LANES)
      $error("ADDR_BYTE out of range for AW/W lanes");
  end

  assign addr_byte = addr_q[ADDR_BYTE*W +: W];

  mio_sync #(.W(W), .STAGES(SYNC_LEN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pad_in),
    .d_out (din_sync)
  );

  mio_alat #(.AW(AW)) u_alat (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (ale),
    .ad_in  (ad_in),
    .addr_q (addr_q)
  );

  mio_regs #(.W(W), .HAS_CTRL(HAS_CTRL)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (bus_cs),
    .wr       (bus_wr),
    .ofs      (bus_ofs),
    .wdata    (bus_wdata),
    .din_sync (din_sync),
    .ctrl_q   (ctrl_q),
    .dir_q    (dir_q),
    .dout_q   (dout_q),
    .rdata    (bus_rdata)
  );

  mio_pinmux #(.W(W)) u_pinmux (
    .ctrl      (ctrl_q),
    .dir       (dir_q),
    .dout      (dout_q),
    .plc_sel   (plc_sel),
    .plc_out   (plc_out),
    .oe_term   (oe_term),
    .addr_byte (addr_byte),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );
endmodule

// File: rtl/mio_port_chk.sv
module mio_port_chk #(
  parameter int W  = 8,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_cs,
  input logic          bus_wr,
  input logic [1:0]    bus_ofs,
  input logic [W-1:0]  bus_rdata,
  input logic          ale,
  input logic [W-1:0]  plc_sel,
  input logic [W-1:0]  plc_out,
  input logic [W-1:0]  oe_term,
  input logic [W-1:0]  pad_in,
  input logic [W-1:0]  pad_out,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  ctrl_q,
  input logic [W-1:0]  dout_q,
  input logic [W-1:0]  addr_byte,
  input logic [AW-1:0] addr_q
);
  logic       ale_d;
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_d     <= 1'b0;
      since_rst <= 2'd0;
    end else begin
      ale_d <= ale;
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end
  end

  AST_DIR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q & ~pad_oe) == '0);  // R3
  AST_UNDRIVEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_q & ~oe_term) == '0);  // R3
  AST_REG_MODE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((~plc_sel & ~ctrl_q) & (pad_out ^ dout_q)) == '0);  // R2
  AST_LOGIC_MODE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (plc_sel & (pad_out ^ plc_out)) == '0);  // R4
  AST_ADDR_MODE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((~plc_sel & ctrl_q) & (pad_out ^ addr_byte)) == '0);  // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale_d && !ale) |=> $stable(addr_q));  // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cs && !bus_wr) |=> $stable(bus_rdata));  // R11
  AST_DIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && bus_cs && !bus_wr && bus_ofs == 2'd3)
      |=> bus_rdata == $past(pad_in, 3));  // R8
endmodule

bind mio_port mio_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_cs    (bus_cs),
  .bus_wr    (bus_wr),
  .bus_ofs   (bus_ofs),
  .bus_rdata (bus_rdata),
  .ale       (ale),
  .plc_sel   (plc_sel),
  .plc_out   (plc_out),
  .oe_term   (oe_term),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .dir_q     (dir_q),
  .ctrl_q    (ctrl_q),
  .dout_q    (dout_q),
  .addr_byte (addr_byte),
  .addr_q    (addr_q)
);

// File: tb/sim_mio_port.sv
`timescale 1ns/1ps
module sim_mio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_ofs = '0;
  logic [7:0]  bus_wdata = '0;
  logic        ale = 1'b0;
  logic [15:0] ad_in = '0;
  logic [7:0]  plc_sel = '0, plc_out = '0, oe_term = '0, pad_in = '0;
  logic [7:0]  rd [3];
  logic [7:0]  po [3];
  logic [7:0]  poe [3];

  int checks = 0, errors = 0;
  logic [7:0]  m_ctrl [3];
  logic [7:0]  m_dir, m_dout;
  logic [15:0] m_addr;

  always #2.5 clk = ~clk;

  mio_port u0 (.clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_ofs(bus_ofs),
    .bus_wdata(bus_wdata), .bus_rdata(rd[0]), .ale(ale), .ad_in(ad_in), .plc_sel(plc_sel),
    .plc_out(plc_out), .oe_term(oe_term), .pad_in(pad_in), .pad_out(po[0]), .pad_oe(poe[0]));
  mio_port #(.ADDR_BYTE(1)) u1 (.clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
    .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(rd[1]), .ale(ale), .ad_in(ad_in),
    .plc_sel(plc_sel), .plc_out(plc_out), .oe_term(oe_term), .pad_in(pad_in),
    .pad_out(po[1]), .pad_oe(poe[1]));
  mio_port #(.HAS_CTRL(1'b0)) u2 (.clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
    .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(rd[2]), .ale(ale), .ad_in(ad_in),
    .plc_sel(plc_sel), .plc_out(plc_out), .oe_term(oe_term), .pad_in(pad_in),
    .pad_out(po[2]), .pad_oe(poe[2]));

  function automatic logic [7:0] exp_out(input logic [7:0] ctl, input logic [7:0] dout,
                                         input logic [7:0] sel, input logic [7:0] plo,
                                         input logic [7:0] abyte);
    return (sel & plo) | (~sel & ctl & abyte) | (~sel & ~ctl & dout);
  endfunction

  function automatic logic [7:0] abyte_of(input int k);
    return (k == 1) ? m_addr[15:8] : m_addr[7:0];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_pins(input string req);
    #1;
    for (int k = 0; k < 3; k++) begin
      check({req, " pad_out R2 R4 R5 R7 R10"}, po[k],
            exp_out(m_ctrl[k], m_dout, plc_sel, plc_out, abyte_of(k)));
      check({req, " pad_oe R3"}, poe[k], m_dir | oe_term);
    end
  endtask

  task automatic bus_write(input logic [1:0] ofs, input logic [7:0] data);
    @(negedge clk);
    bus_cs = 1'b1; bus_wr = 1'b1; bus_ofs = ofs; bus_wdata = data;
    @(negedge clk);
    bus_cs = 1'b0; bus_wr = 1'b0;
    for (int k = 0; k < 3; k++)
      if (ofs == 2'd0) m_ctrl[k] = (k == 2) ? 8'h00 : data;
    if (ofs == 2'd1) m_dir  = data;
    if (ofs == 2'd2) m_dout = data;
  endtask

  task automatic bus_read(input logic [1:0] ofs, input string req, input logic [7:0] din_exp);
    @(negedge clk);
    bus_cs = 1'b1; bus_wr = 1'b0; bus_ofs = ofs;
    @(negedge clk);
    bus_cs = 1'b0;
    for (int k = 0; k < 3; k++) begin
      case (ofs)
        2'd0: check({req, " R9 R10 ctrl"}, rd[k], m_ctrl[k]);
        2'd1: check({req, " R9 dir"}, rd[k], m_dir);
        2'd2: check({req, " R9 dout"}, rd[k], m_dout);
        default: check({req, " R8 din"}, rd[k], din_exp);
      endcase
    end
  endtask

  task automatic ale_cycle(input logic [15:0] a);
    @(negedge clk);
    ale = 1'b1; ad_in = a;
    @(negedge clk);
    ale = 1'b0; ad_in = ~a;
    @(negedge clk);
    m_addr = a;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e7a11));
    for (int k = 0; k < 3; k++) m_ctrl[k] = '0;
    m_dir = '0; m_dout = '0; m_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int k = 0; k < 3; k++) begin
      check("R1 rdata", rd[k], 8'h00);
      check("R1 pad_oe", poe[k], 8'h00);
    end
    bus_read(2'd0, "R1", 8'h00);
    bus_read(2'd1, "R1", 8'h00);
    bus_read(2'd2, "R1", 8'h00);

    // R2: register-driven mode
    bus_write(2'd2, 8'hA5);
    check_pins("R2 dout");
    bus_write(2'd1, 8'h0F);
    check_pins("R3 dir");
    oe_term = 8'h30;
    check_pins("R3 oe_term");

    // R6 / R5 / R7: address latch and address-out mode
    ale_cycle(16'h3C96);
    bus_write(2'd0, 8'hFF);
    check_pins("R5 R7 addr");
    @(negedge clk); ad_in = 16'h1234;
    @(negedge clk); ad_in = 16'hFFFF;
    check_pins("R6 hold while ale low");
    @(negedge clk); ale = 1'b1; ad_in = 16'h1111;
    @(negedge clk); ad_in = 16'h2222;
    @(negedge clk); ad_in = 16'h4BE1;
    check_pins("R6 no commit while high");
    @(negedge clk); ale = 1'b0; ad_in = 16'h0000;
    @(negedge clk); m_addr = 16'h4BE1;
    check_pins("R6 last tracked value");

    // R4: logic mode overrides control bit
    plc_sel = 8'hC3; plc_out = 8'h5A;
    check_pins("R4 logic override");

    // R9: write to data-in offset ignored
    bus_write(2'd3, 8'h77);
    bus_read(2'd0, "R9 din write ignored", 8'h00);
    bus_read(2'd1, "R9 din write ignored", 8'h00);
    bus_read(2'd2, "R9 din write ignored", 8'h00);

    // R8: synchronizer latency
    @(negedge clk); pad_in = 8'h9C;
    repeat (3) @(negedge clk);
    bus_read(2'd3, "R8 settled", 8'h9C);
    pad_in = 8'h63;
    bus_read(2'd3, "R8 too early", 8'h9C);
    @(negedge clk);
    bus_read(2'd3, "R8 after two edges", 8'h63);

    // R11: rdata holds without a read
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) check("R11 hold", rd[k], 8'h63);

    // R10: the build without a control register stays in register mode
    plc_sel = 8'h00;
    bus_write(2'd0, 8'hF0);
    check_pins("R10 no ctrl");
    bus_read(2'd0, "R10", 8'h00);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: bus_write(2'($urandom % 4), 8'($urandom));
        1: ale_cycle(16'($urandom));
        2: begin
          @(negedge clk);
          plc_sel = 8'($urandom); plc_out = 8'($urandom); oe_term = 8'($urandom);
          ad_in = 16'($urandom);
        end
        3: begin
          @(negedge clk); pad_in = 8'($urandom);
          repeat (3) @(negedge clk);
        end
        default: bus_read(2'($urandom % 4), "random", pad_in);
      endcase
      check_pins("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule